// File: doc/BRIEF.md
# Sector Page-Buffer Programming Engine

This block models the internal write path of a byte-wide nonvolatile memory that is rewritten one sector at a time. A host writes bytes through a simple strobe port. The first write opens a load sequence and fixes the target sector. Later writes fill a 128-byte page buffer in any order, and each write restarts a load-window timer. When no byte arrives within the window, the engine commits the whole sector to its storage array in one program phase of fixed length. It then returns to idle.

While the program phase runs, the write port is locked. A read then returns a status byte instead of array data. Bit 7 of that byte is the inverse of bit 7 of the last byte loaded, and bit 6 flips on each status read. A mode input picks between two commit styles. Auto-clear replaces the whole sector, so unloaded bytes become FFh. Merge mode ANDs the loaded bytes into the stored contents and leaves the others untouched. The window length and the program time are parameters in clock cycles, so a host clock can be used or simulation can use short values. The array holds 2^SECT_W sectors of 128 bytes each. A full-size part uses SECT_W = 10; the default is kept small so that the register model stays light.

Top module: `pageprog_engine`

## Requirements
- R1: A byte address is {sector, offset}: the upper SECT_W bits name the sector and the low 7 bits name the byte within it. A read with rdEn outside the program phase returns the array byte at that address.
- R2: The sector is taken from the first write of a load sequence. The sector bits of later writes in the same sequence are ignored, and only their low 7 bits are used.
- R3: Bytes may be loaded in any order. A second write to the same offset in one sequence replaces the first, and the last value written is the one committed.
- R4: Each write restarts the load window. A write that arrives up to LOAD_WIN cycles after the previous one is accepted. After LOAD_WIN cycles with no write, loading ends and the program phase begins. From the last write's capture edge to the fall of busy there are LOAD_WIN+PROG_CYC cycles.
- R5: busy rises on the edge that captures the first write and stays high through loading and the PROG_CYC-cycle program phase. busy falls on the edge that updates the array.
- R6: With autoClear sampled high at the first write, loaded bytes take their loaded value and unloaded bytes of the sector become FFh. A later change of autoClear within the sequence has no effect.
- R7: With autoClear sampled low at the first write, each loaded byte becomes old AND loaded, and unloaded bytes keep their old value.
- R8: A read during the program phase returns a status byte. Bit 7 is the inverse of bit 7 of the last byte loaded, and bits 5..0 are zero.
- R9: Bit 6 of the status byte is 0 on the first status read of a sequence and alternates on each later status read.
- R10: Write strobes during the program phase are ignored and alter no array byte.
- R11: After reset, busy is 0, rdData is 00h and every array byte reads FFh.
- R12: rdData changes on the clock edge after a cycle with rdEn high and holds its value while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | SECT_W+7 | Write address {sector, offset} |
| wrData | input | 8 | Write data |
| autoClear | input | 1 | Commit style, sampled at the first write: 1 replaces the sector, 0 merges by AND |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | SECT_W+7 | Read address {sector, offset} |
| rdData | output | 8 | Registered read data or program status |
| busy | output | 1 | Load or program phase in progress |

## Verification
The bench builds the engine with SECT_W = 2, LOAD_WIN = 8 and PROG_CYC = 20. With these values a full load, expiry and commit takes a few dozen cycles, so several sequences can run back to back. One write can be placed exactly at the edge of the window, and status polls and locked-out writes fit inside the program phase. The four-sector array is small enough that a stray sector address from a later write shows up as a wrong byte in a sector that was read back.

// File: rtl/pageprog_pkg.sv
`timescale 1ns/1ps
package pageprog_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadByte;   // accept wrData into the page buffer
    logic startSeq;   // first byte of a new sequence
    logic commit;     // last program cycle: update the array
    logic polling;    // program phase, reads return status
  } pgStrobe_t;
endpackage

// File: rtl/pageprog_ctrl.sv
`timescale 1ns/1ps
module pageprog_ctrl
  import pageprog_pkg::*;
#(
  parameter int SECT_W   = 4,
  parameter int LOAD_WIN = 15000,
  parameter int PROG_CYC = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SECT_W-1:0] wrSec,
  input  logic              autoClear,
  output pgStrobe_t         strb,
  output logic [SECT_W-1:0] secLatched,
  output logic              autoClrLatched,
  output logic              busy
);
  localparam int WIN_W = $clog2(LOAD_WIN + 1);
  localparam int PRG_W = $clog2(PROG_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOAD_WIN - 1);
  localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);

  pgState_t         state;
  logic [WIN_W-1:0] winCnt;
  logic [PRG_W-1:0] progCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      winCnt         <= '0;
      progCnt        <= '0;
      secLatched     <= '0;
      autoClrLatched <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wrEn) begin
            state          <= ST_LOAD;
            winCnt         <= '0;
            secLatched     <= wrSec;
            autoClrLatched <= autoClear;
          end
        end
        ST_LOAD: begin
          if (wrEn) begin
            winCnt <= '0;
          end else if (winCnt == WIN_LAST) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (progCnt == PRG_LAST) begin
            state <= ST_IDLE;
          end else begin
            progCnt <= progCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.loadByte = wrEn && (state == ST_IDLE || state == ST_LOAD);
    strb.startSeq = wrEn && (state == ST_IDLE);
    strb.polling  = (state == ST_PROG);
    strb.commit   = (state == ST_PROG) && (progCnt == PRG_LAST);
    busy          = (state != ST_IDLE);
  end
endmodule

// File: rtl/pageprog_dp.sv
`timescale 1ns/1ps
module pageprog_dp
  import pageprog_pkg::*;
#(
  parameter int SECT_W  = 4,
  parameter int BYTE_AW = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  pgStrobe_t          strb,
  input  logic [SECT_W-1:0]  secLatched,
  input  logic               autoClrLatched,
  input  logic [BYTE_AW-1:0] wrByte,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdEn,
  input  logic [SECT_W-1:0]  rdSec,
  input  logic [BYTE_AW-1:0] rdByte,
  output logic [DATA_W-1:0]  rdData
);
  localparam int NBYTES = 1 << BYTE_AW;
  localparam int NSECT  = 1 << SECT_W;
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [DATA_W-1:0] pageBuf [NBYTES];
  logic [NBYTES-1:0] loadedMask;
  logic [DATA_W-1:0] lastByte;
  logic              togBit;
  logic [DATA_W-1:0] colRead [NBYTES];

  // page buffer: contents only matter where loadedMask is set
  always_ff @(posedge clk) begin
    if (strb.loadByte) pageBuf[wrByte] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadedMask <= '0;
      lastByte   <= '0;
    end else if (strb.startSeq) begin
      loadedMask <= {{(NBYTES-1){1'b0}}, 1'b1} << wrByte;
      lastByte   <= wrData;
    end else if (strb.loadByte) begin
      loadedMask[wrByte] <= 1'b1;
      lastByte           <= wrData;
    end
  end

  // one storage column per byte offset, all committed in the same cycle
  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_col
    logic [DATA_W-1:0] col [NSECT];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int s = 0; s < NSECT; s++) col[s] <= ERASED;
      end else if (strb.commit) begin
        if (loadedMask[gb]) begin
          col[secLatched] <= autoClrLatched ? pageBuf[gb]
                                            : (col[secLatched] & pageBuf[gb]);
        end else if (autoClrLatched) begin
          col[secLatched] <= ERASED;
        end
      end
    end

    assign colRead[gb] = col[rdSec];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      togBit <= 1'b0;
    end else if (strb.startSeq) begin
      togBit <= 1'b0;
    end else if (rdEn && strb.polling) begin
      togBit <= ~togBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      if (strb.polling) rdData <= {~lastByte[DATA_W-1], togBit, {(DATA_W-2){1'b0}}};
      else              rdData <= colRead[rdByte];
    end
  end
endmodule

// File: rtl/pageprog_engine.sv
`timescale 1ns/1ps
module pageprog_engine
  import pageprog_pkg::*;
#(
  parameter int SECT_W   = 4,
  parameter int BYTE_AW  = 7,
  parameter int LOAD_WIN = 15000,
  parameter int PROG_CYC = 500000,
  localparam int ADDR_W  = SECT_W + BYTE_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              autoClear,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy
);
  pgStrobe_t         strb;
  logic [SECT_W-1:0] secLatched;
  logic              autoClrLatched;

  pageprog_ctrl #(
    .SECT_W(SECT_W), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .wrSec(wrAddr[ADDR_W-1:BYTE_AW]), .autoClear(autoClear),
    .strb(strb), .secLatched(secLatched),
    .autoClrLatched(autoClrLatched), .busy(busy)
  );

  pageprog_dp #(
    .SECT_W(SECT_W), .BYTE_AW(BYTE_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .secLatched(secLatched), .autoClrLatched(autoClrLatched),
    .wrByte(wrAddr[BYTE_AW-1:0]), .wrData(wrData),
    .rdEn(rdEn), .rdSec(rdAddr[ADDR_W-1:BYTE_AW]),
    .rdByte(rdAddr[BYTE_AW-1:0]), .rdData(rdData)
  );
endmodule

// File: rtl/pageprog_chk.sv
`timescale 1ns/1ps
module pageprog_chk
  import pageprog_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [7:0]        rdData,
  input logic              busy,
  input pgStrobe_t         strb,
  input logic [SECT_W-1:0] secLatched
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy) |=> busy); // R5

  AST_COMMIT_FREES: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !busy); // R5

  AST_IDLE_NO_POLL: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strb.polling); // R8

  AST_POLL_LOWBITS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && strb.polling) |=> (rdData[5:0] == 6'd0)); // R8

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdEn && strb.polling) && rdEn && strb.polling) |=> (rdData[6] != $past(rdData[6]))); // R9

  AST_SECTOR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(secLatched)); // R2

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> $stable(rdData)); // R12
endmodule

bind pageprog_engine pageprog_chk #(.SECT_W(SECT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
  .busy(busy), .strb(strb), .secLatched(secLatched)
);

// File: tb/sim_pageprog_engine.sv
`timescale 1ns/1ps
module sim_pageprog_engine;
  localparam int SECT_W   = 2;
  localparam int BYTE_AW  = 7;
  localparam int LOAD_WIN = 8;
  localparam int PROG_CYC = 20;
  localparam int ADDR_W   = SECT_W + BYTE_AW;
  localparam int NB       = 1 << ADDR_W;
  localparam int PB       = 1 << BYTE_AW;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic              autoClear = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData;
  logic              busy;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  live    = 1'b0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  pageprog_engine #(
    .SECT_W(SECT_W), .BYTE_AW(BYTE_AW), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .autoClear(autoClear), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .busy(busy)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] mArr [NB];
  logic [7:0] mBuf [PB];
  bit         mLd  [PB];
  int         mPhase, mQuiet, mProg, mSec;
  logic [7:0] mLast, mRd;
  bit         mTog, mAc;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NB; i++) mArr[i] = 8'hFF;
      mPhase = 0; mQuiet = 0; mProg = 0; mSec = 0;
      mLast = 8'h00; mRd = 8'h00; mTog = 0; mAc = 0;
    end else begin
      if (rdEn) begin
        if (mPhase == 2) begin
          mRd  = {~mLast[7], mTog, 6'b0};
          mTog = !mTog;
        end else begin
          mRd = mArr[rdAddr];
        end
      end
      if (mPhase == 0) begin
        if (wrEn) begin
          mSec = int'(wrAddr) / PB;
          for (int b = 0; b < PB; b++) mLd[b] = 0;
          mBuf[int'(wrAddr) % PB] = wrData;
          mLd[int'(wrAddr) % PB]  = 1;
          mLast = wrData; mTog = 0; mAc = autoClear; mQuiet = 0;
          mPhase = 1;
        end
      end else if (mPhase == 1) begin
        if (wrEn) begin
          mBuf[int'(wrAddr) % PB] = wrData;
          mLd[int'(wrAddr) % PB]  = 1;
          mLast = wrData; mQuiet = 0;
        end else begin
          mQuiet++;
          if (mQuiet == LOAD_WIN) begin mPhase = 2; mProg = 0; end
        end
      end else begin
        mProg++;
        if (mProg == PROG_CYC) begin
          for (int b = 0; b < PB; b++) begin
            if (mLd[b]) mArr[mSec*PB+b] = mAc ? mBuf[b] : (mArr[mSec*PB+b] & mBuf[b]);
            else if (mAc) mArr[mSec*PB+b] = 8'hFF;
          end
          mPhase = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (live && rstN) begin
      chk("R5 busy", int'(busy), (mPhase != 0) ? 1 : 0);
      chk("R12 rdData", int'(rdData), int'(mRd));
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic doWrite(input int sec, input int off, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(sec*PB + off); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input int sec, input int off, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = ADDR_W'(sec*PB + off);
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R5 watchdog act=busy-or-hung exp=finished");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    chk("R11 busy at reset", int'(busy), 0);
    chk("R11 rdData at reset", int'(rdData), 0);
    rstN = 1'b1; live = 1'b1;
    doRead(0, 0, v);   chk("R11 erased 0/0", v, 8'hFF);
    doRead(3, 127, v); chk("R11 erased 3/127", v, 8'hFF);

    // A: auto-clear, sector taken from first write, overwrite, polls
    autoClear = 1'b1;
    doWrite(1, 5, 8'h5A);
    chk("R5 busy after first write", int'(busy), 1);
    doWrite(2, 3, 8'hC3);          // sector bits ignored (R2)
    doWrite(1, 5, 8'hA5);          // overwrite (R3)
    repeat (LOAD_WIN) @(negedge clk);
    doRead(0, 0, v); chk("R8 poll bit7 after A5 / R9 first", v, 8'h00);
    doRead(0, 0, v); chk("R9 second poll toggles", v, 8'h40);
    doRead(0, 0, v); chk("R9 third poll toggles back", v, 8'h00);
    doWrite(3, 0, 8'h00);          // ignored during program (R10)
    chk("R5 busy during program", int'(busy), 1);
    waitIdle();
    doRead(1, 5, v); chk("R3 last overwrite wins", v, 8'hA5);
    doRead(1, 3, v); chk("R2 R1 byte into first sector", v, 8'hC3);
    doRead(1, 0, v); chk("R6 unloaded cleared", v, 8'hFF);
    doRead(2, 3, v); chk("R2 other sector untouched", v, 8'hFF);
    doRead(3, 0, v); chk("R10 write in program ignored", v, 8'hFF);

    // B: merge mode, write at the very edge of the window
    autoClear = 1'b0;
    doWrite(1, 5, 8'h3C);
    repeat (LOAD_WIN - 2) @(negedge clk);
    doWrite(1, 7, 8'h0F);          // gap of exactly LOAD_WIN cycles (R4)
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R4 R5 last write to idle", n, LOAD_WIN + PROG_CYC);
    doRead(1, 5, v); chk("R7 AND merge", v, 8'h24);
    doRead(1, 7, v); chk("R4 edge write accepted", v, 8'h0F);
    doRead(1, 3, v); chk("R7 unloaded kept", v, 8'hC3);

    // C: auto-clear latched at first write, mode changed mid-load
    autoClear = 1'b1;
    doWrite(1, 5, 8'h7E);
    autoClear = 1'b0;
    doWrite(1, 2, 8'h11);
    repeat (LOAD_WIN) @(negedge clk);
    doRead(2, 0, v); chk("R8 poll bit7 after 11 / R9 first", v, 8'h80);
    doRead(2, 0, v); chk("R9 second poll", v, 8'hC0);
    waitIdle();
    doRead(1, 5, v); chk("R6 replaced not merged", v, 8'h7E);
    doRead(1, 3, v); chk("R6 latched clear", v, 8'hFF);
    doRead(1, 2, v); chk("R1 loaded byte", v, 8'h11);
    repeat (3) @(negedge clk);
    chk("R12 holds without rdEn", int'(rdData), 8'h11);
    finishRun();
  end
endmodule